// File: doc/BRIEF.md
# Protection region configuration register file

This block is the software-visible register file behind a memory protection checker. It keeps the setup of eight protection regions: a base address, an enable, a size code, a subregion-disable mask and an attribute field. The setup of every region is driven out on flat vectors for a separate region checker. Software reaches the storage through a small indirect window. A selector register picks one region. A base register and an attribute/size register then read and write that region.

A base write that carries a valid flag also loads the selector from its own low bits, so one word can both pick a region and place it. Three more base/attribute pairs follow the main pair at consecutive word offsets. With these, a burst of word writes can program up to four regions. The attribute/size register accepts byte, halfword and word writes. Software can therefore clear the enable in one half, change the rest, and set the enable again. Accesses with a bad size or bad alignment, and accesses to unmapped offsets, get a bus-error response and change nothing.

Every request is answered one cycle later with a single response. Write data and read data use their natural byte lanes.

Top module: `prot_region_regs`

## Requirements
- R1: After reset, every region is disabled, every stored field reads as zero, and the selector is 0.
- R2: A word write at offset 0x00 with a value below the region count loads the selector. A larger value is ignored. Reads of 0x00 return the selector in the low bits and zero elsewhere.
- R3: A word write at offset 0x04 with bit 4 clear stores bits 31:5 into the selected region's base. Bits 4:0 are not stored.
- R4: A word write at 0x04 with bit 4 (the valid flag) set and a region field (bits 3:0) below the region count does two things. It loads the selector from that field and stores bits 31:5 into that region's base. If the field is out of range, the whole write is ignored.
- R5: A read of 0x04 returns the selected region's base in bits 31:5, 0 in bit 4, and the selector in bits 3:0.
- R6: The word at offset 0x08 holds the selected region's fields: bit 0 is the enable, bits 5:1 are the size code, bits 15:8 are the subregion-disable mask, and bits 31:16 are the attributes. Only attribute bits 16–21, 24–26 and 28 are writable. All other bits read as 0.
- R7: A halfword write at 0x08 or at 0x0A, or a byte write at 0x08–0x0B, changes only its own bytes. Data travels on the natural lanes: the byte at offset k uses bits 8k+7:8k.
- R8: The subregion-disable mask reads back exactly as written, whatever the size code.
- R9: The pairs at offsets 0x0C/0x10, 0x14/0x18 and 0x1C/0x20 behave exactly like 0x04/0x08, including the valid-flag selection.
- R10: The size codes are 0 for byte, 1 for halfword, 2 for word and 3 for illegal. The selector and base registers take only aligned words. A halfword needs address bit 0 clear, and a word needs address bits 1:0 clear. Offsets 0x24 to 0x3F are unmapped. Any access that breaks these rules responds with error = 1 and read data 0, and changes no state.
- R11: Every request gets exactly one response, in the following cycle. Write responses and error responses carry read data 0. A read returns the addressed register.
- R12: The per-region output vectors show a write in the cycle after it, and a single write changes at most one region's enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_wdata | input | 32 | Write data on natural byte lanes |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Bus error |
| rsp_rdata | output | 32 | Read data |
| cfg_en | output | NREG | Region enables |
| cfg_size | output | NREG*5 | Size codes, 5 bits per region |
| cfg_srd | output | NREG*8 | Subregion-disable masks |
| cfg_attr | output | NREG*16 | Attribute fields |
| cfg_base | output | NREG*27 | Base address bits 31:5 |

## Verification
On every cycle, the assertions check the following:
- Each request is paired with exactly one response in the next cycle.
- Error and write responses carry zero data.
- A misaligned word always errors.
- An errored access leaves the selector and every region output untouched.
- No write touches more than one region's enable.

Only the bench scenarios can show the rest: the values stored by valid-flag base writes, the lane placement of byte and halfword writes, the behaviour of the alias pairs, and that out-of-range region numbers are ignored. They do this by reading the registers back and comparing the region output vectors against expected values.

// File: rtl/prot_regs_pkg.sv
package prot_regs_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_NUM  = 2'd1,
        K_BASE = 2'd2,
        K_ATTR = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] be;
        logic       err;
    } dec_t;

    localparam int          DATA_W     = 32;
    localparam int          BASE_LSB   = 5;
    localparam int          BASE_W     = DATA_W - BASE_LSB;
    localparam int          VALID_BIT  = 4;
    localparam int          FIELD_W    = 4;
    localparam int          SIZE_W     = 5;
    localparam int          SRD_W      = 8;
    localparam int          ATTR_W     = 16;
    localparam logic [31:0] ATTR_WMASK = 32'h173F_FF3F;

    function automatic logic [3:0] lane_mask(input acc_size_e sz, input logic [1:0] off);
        logic [3:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001 << off;
            SZ_HALF: m = 4'b0011 << off;
            SZ_WORD: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/prot_regs_decode.sv
module prot_regs_decode
    import prot_regs_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int ALIAS_PAIRS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int LAST_IDX = 2 + 2 * ALIAS_PAIRS;

    logic [IDX_W-1:0] idx;
    logic [1:0]       off;
    acc_size_e        sz;

    assign idx = addr[ADDR_W-1:2];
    assign off = addr[1:0];
    assign sz  = acc_size_e'(size);

    always_comb begin
        dec.kind = K_NONE;
        if (int'(idx) == 0)
            dec.kind = K_NUM;
        else if (int'(idx) <= LAST_IDX)
            dec.kind = idx[0] ? K_BASE : K_ATTR;

        dec.err = 1'b0;
        if (sz == SZ_BAD || dec.kind == K_NONE)
            dec.err = 1'b1;
        else if (dec.kind == K_NUM || dec.kind == K_BASE)
            dec.err = (sz != SZ_WORD) || (off != 2'b00);
        else if (sz == SZ_HALF)
            dec.err = off[0];
        else if (sz == SZ_WORD)
            dec.err = (off != 2'b00);

        dec.be = dec.err ? 4'b0000 : lane_mask(sz, off);
    end
endmodule

// File: rtl/prot_region_slot.sv
module prot_region_slot
    import prot_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_base,
    input  logic [BASE_W-1:0] base_in,
    input  logic              wr_attr,
    input  logic [3:0]        attr_be,
    input  logic [DATA_W-1:0] attr_in,
    output logic [BASE_W-1:0] base_q,
    output logic [DATA_W-1:0] attr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            attr_q <= '0;
        end else begin
            if (wr_base)
                base_q <= base_in;
            if (wr_attr) begin
                for (int b = 0; b < 4; b++) begin
                    if (attr_be[b])
                        attr_q[8*b +: 8] <= attr_in[8*b +: 8] & ATTR_WMASK[8*b +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/prot_regs_readmux.sv
module prot_regs_readmux
    import prot_regs_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int SEL_W = 3
) (
    input  reg_kind_e                kind,
    input  logic [SEL_W-1:0]         sel,
    input  logic [NREG*BASE_W-1:0]   bases,
    input  logic [NREG*DATA_W-1:0]   attrs,
    output logic [DATA_W-1:0]        rdata
);
    logic [BASE_W-1:0] base_sel;
    logic [DATA_W-1:0] attr_sel;
    logic [FIELD_W-1:0] sel_field;

    assign base_sel  = bases[int'(sel)*BASE_W +: BASE_W];
    assign attr_sel  = attrs[int'(sel)*DATA_W +: DATA_W];
    assign sel_field = FIELD_W'(sel);

    always_comb begin
        case (kind)
            K_NUM:   rdata = {{(DATA_W-SEL_W){1'b0}}, sel};
            K_BASE:  rdata = {base_sel, 1'b0, sel_field};
            K_ATTR:  rdata = attr_sel;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
    import prot_regs_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int ADDR_W      = 6,
    parameter int ALIAS_PAIRS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_size,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [31:0]            rsp_rdata,
    output logic [NREG-1:0]        cfg_en,
    output logic [NREG*5-1:0]      cfg_size,
    output logic [NREG*8-1:0]      cfg_srd,
    output logic [NREG*16-1:0]     cfg_attr,
    output logic [NREG*27-1:0]     cfg_base
);
    localparam int SEL_W = $clog2(NREG);

    dec_t                   dec;
    logic [SEL_W-1:0]       sel_q;
    logic                   do_wr;
    logic                   num_wr;
    logic                   base_wr;
    logic                   attr_wr;
    logic                   vflag;
    logic [FIELD_W-1:0]     field;
    logic                   field_ok;
    logic [SEL_W-1:0]       base_tgt;
    logic [NREG*BASE_W-1:0] bases;
    logic [NREG*DATA_W-1:0] attrs;
    logic [DATA_W-1:0]      rd_word;

    prot_regs_decode #(.ADDR_W(ADDR_W), .ALIAS_PAIRS(ALIAS_PAIRS)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    assign do_wr    = req_valid && req_write && !dec.err;
    assign vflag    = req_wdata[VALID_BIT];
    assign field    = req_wdata[FIELD_W-1:0];
    assign field_ok = int'(field) < NREG;
    assign num_wr   = do_wr && dec.kind == K_NUM && (req_wdata < 32'(NREG));
    assign base_wr  = do_wr && dec.kind == K_BASE && (!vflag || field_ok);
    assign attr_wr  = do_wr && dec.kind == K_ATTR;
    assign base_tgt = vflag ? field[SEL_W-1:0] : sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (num_wr)
            sel_q <= req_wdata[SEL_W-1:0];
        else if (base_wr && vflag)
            sel_q <= field[SEL_W-1:0];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic [DATA_W-1:0] a_q;
        logic [BASE_W-1:0] b_q;

        prot_region_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_base (base_wr && (int'(base_tgt) == i)),
            .base_in (req_wdata[DATA_W-1:BASE_LSB]),
            .wr_attr (attr_wr && (int'(sel_q) == i)),
            .attr_be (dec.be),
            .attr_in (req_wdata),
            .base_q  (b_q),
            .attr_q  (a_q)
        );

        assign bases[i*BASE_W +: BASE_W] = b_q;
        assign attrs[i*DATA_W +: DATA_W] = a_q;
        assign cfg_base[i*BASE_W +: BASE_W] = b_q;
        assign cfg_en[i]                    = a_q[0];
        assign cfg_size[i*SIZE_W +: SIZE_W] = a_q[5:1];
        assign cfg_srd[i*SRD_W +: SRD_W]    = a_q[15:8];
        assign cfg_attr[i*ATTR_W +: ATTR_W] = a_q[31:16];
    end

    prot_regs_readmux #(.NREG(NREG), .SEL_W(SEL_W)) u_rmux (
        .kind  (dec.kind),
        .sel   (sel_q),
        .bases (bases),
        .attrs (attrs),
        .rdata (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.err;
            rsp_rdata <= (req_valid && !req_write && !dec.err) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/prot_region_regs_chk.sv
module prot_region_regs_chk #(
    parameter int NREG   = 8,
    parameter int ADDR_W = 6,
    parameter int SEL_W  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [1:0]          req_size,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic [31:0]         rsp_rdata,
    input logic [NREG-1:0]     cfg_en,
    input logic [NREG*5-1:0]   cfg_size,
    input logic [NREG*8-1:0]   cfg_srd,
    input logic [NREG*16-1:0]  cfg_attr,
    input logic [NREG*27-1:0]  cfg_base,
    input logic [SEL_W-1:0]    sel_q
);
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_en == '0) && (cfg_base == '0) && (sel_q == '0) && !rsp_valid);

    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r11_write_zero_data: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0));

    a_r10_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == 32'd0) && rsp_valid);

    a_r10_misaligned_word: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> rsp_err);

    a_r10_err_no_change: assert property (@(posedge clk) disable iff (rst)
        (rsp_err && !$past(rst)) |-> $stable(cfg_en) && $stable(cfg_size) && $stable(cfg_srd)
                     && $stable(cfg_attr) && $stable(cfg_base) && $stable(sel_q));

    a_r12_one_enable: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(cfg_en ^ $past(cfg_en)) <= 1));
endmodule

bind prot_region_regs prot_region_regs_chk #(
    .NREG(NREG), .ADDR_W(ADDR_W), .SEL_W($clog2(NREG))
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_en(cfg_en),
    .cfg_size(cfg_size), .cfg_srd(cfg_srd), .cfg_attr(cfg_attr),
    .cfg_base(cfg_base), .sel_q(sel_q)
);

// File: tb/prot_region_regs_tb.sv
`timescale 1ns/1ps
module prot_region_regs_tb;
    localparam int NREG = 8;
    localparam int NV   = 40;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        err;
        logic [31:0] rdata;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'h00, 2'd2, 32'h0,          1'b0, 32'h0,          4'd1 },  // R1
        '{1'b0, 6'h04, 2'd2, 32'h0,          1'b0, 32'h0,          4'd1 },  // R1
        '{1'b0, 6'h08, 2'd2, 32'h0,          1'b0, 32'h0,          4'd1 },  // R1
        '{1'b1, 6'h00, 2'd2, 32'h3,          1'b0, 32'h0,          4'd2 },  // R2
        '{1'b0, 6'h00, 2'd2, 32'h0,          1'b0, 32'h3,          4'd2 },  // R2
        '{1'b1, 6'h00, 2'd2, 32'h9,          1'b0, 32'h0,          4'd2 },  // R2 ignored
        '{1'b0, 6'h00, 2'd2, 32'h0,          1'b0, 32'h3,          4'd2 },  // R2
        '{1'b1, 6'h04, 2'd2, 32'h2000_00FF,  1'b0, 32'h0,          4'd4 },  // R4 bad field
        '{1'b0, 6'h04, 2'd2, 32'h0,          1'b0, 32'h0000_0003,  4'd4 },  // R4
        '{1'b1, 6'h04, 2'd2, 32'h2000_00E5,  1'b0, 32'h0,          4'd3 },  // R3
        '{1'b0, 6'h04, 2'd2, 32'h0,          1'b0, 32'h2000_00E3,  4'd5 },  // R5
        '{1'b1, 6'h04, 2'd2, 32'h4000_0015,  1'b0, 32'h0,          4'd4 },  // R4
        '{1'b0, 6'h00, 2'd2, 32'h0,          1'b0, 32'h5,          4'd4 },  // R4
        '{1'b0, 6'h04, 2'd2, 32'h0,          1'b0, 32'h4000_0005,  4'd5 },  // R5
        '{1'b1, 6'h08, 2'd2, 32'hFFFF_FFFF,  1'b0, 32'h0,          4'd6 },  // R6
        '{1'b0, 6'h08, 2'd2, 32'h0,          1'b0, 32'h173F_FF3F,  4'd6 },  // R6
        '{1'b1, 6'h08, 2'd1, 32'h0000_0A06,  1'b0, 32'h0,          4'd7 },  // R7
        '{1'b0, 6'h08, 2'd2, 32'h0,          1'b0, 32'h173F_0A06,  4'd8 },  // R8
        '{1'b1, 6'h0A, 2'd1, 32'h0001_0000,  1'b0, 32'h0,          4'd7 },  // R7
        '{1'b0, 6'h08, 2'd2, 32'h0,          1'b0, 32'h0001_0A06,  4'd7 },  // R7
        '{1'b1, 6'h09, 2'd0, 32'h0000_5500,  1'b0, 32'h0,          4'd7 },  // R7
        '{1'b0, 6'h08, 2'd0, 32'h0,          1'b0, 32'h0001_5506,  4'd7 },  // R7
        '{1'b1, 6'h0A, 2'd2, 32'hFFFF_FFFF,  1'b1, 32'h0,          4'd10},  // R10
        '{1'b1, 6'h09, 2'd1, 32'hFFFF_FFFF,  1'b1, 32'h0,          4'd10},  // R10
        '{1'b1, 6'h00, 2'd1, 32'h0000_0001,  1'b1, 32'h0,          4'd10},  // R10
        '{1'b1, 6'h08, 2'd3, 32'hFFFF_FFFF,  1'b1, 32'h0,          4'd10},  // R10
        '{1'b0, 6'h28, 2'd2, 32'h0,          1'b1, 32'h0,          4'd10},  // R10
        '{1'b0, 6'h08, 2'd2, 32'h0,          1'b0, 32'h0001_5506,  4'd10},  // R10
        '{1'b0, 6'h00, 2'd2, 32'h0,          1'b0, 32'h5,          4'd10},  // R10
        '{1'b1, 6'h0C, 2'd2, 32'h6000_0012,  1'b0, 32'h0,          4'd9 },  // R9
        '{1'b1, 6'h10, 2'd2, 32'h0000_0001,  1'b0, 32'h0,          4'd9 },  // R9
        '{1'b1, 6'h14, 2'd2, 32'h8000_0017,  1'b0, 32'h0,          4'd9 },  // R9
        '{1'b1, 6'h18, 2'd2, 32'h0300_0009,  1'b0, 32'h0,          4'd9 },  // R9
        '{1'b0, 6'h1C, 2'd2, 32'h0,          1'b0, 32'h8000_0007,  4'd9 },  // R9
        '{1'b0, 6'h20, 2'd2, 32'h0,          1'b0, 32'h0300_0009,  4'd9 },  // R9
        '{1'b1, 6'h00, 2'd2, 32'h2,          1'b0, 32'h0,          4'd2 },  // R2
        '{1'b0, 6'h04, 2'd2, 32'h0,          1'b0, 32'h6000_0002,  4'd9 },  // R9
        '{1'b0, 6'h08, 2'd2, 32'h0,          1'b0, 32'h0000_0001,  4'd9 },  // R9
        '{1'b1, 6'h04, 2'd0, 32'hFFFF_FFFF,  1'b1, 32'h0,          4'd10},  // R10
        '{1'b0, 6'h00, 2'd2, 32'h0,          1'b0, 32'h2,          4'd11}   // R11
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [5:0]        req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NREG-1:0]   cfg_en;
    logic [NREG*5-1:0] cfg_size;
    logic [NREG*8-1:0] cfg_srd;
    logic [NREG*16-1:0] cfg_attr;
    logic [NREG*27-1:0] cfg_base;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    prot_region_regs #(.NREG(NREG)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_en(cfg_en), .cfg_size(cfg_size), .cfg_srd(cfg_srd),
        .cfg_attr(cfg_attr), .cfg_base(cfg_base)
    );

    task automatic check(input bit ok, input int r, input logic [255:0] act,
                         input logic [255:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [5:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic v, output logic e,
                        output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        v = rsp_valid; e = rsp_err; rd = rsp_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic v, e;
        logic [31:0] rd;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: reset state on the outputs
        check(cfg_en == '0 && cfg_base == '0 && cfg_srd == '0 && cfg_attr == '0 && cfg_size == '0,
              1, 256'(cfg_en), 256'(0), "outputs zero after reset");
        check(rsp_valid == 1'b0, 1, 256'(rsp_valid), 256'(0), "no response after reset");

        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, v, e, rd);
            check(v == 1'b1, 11, 256'(v), 256'(1), $sformatf("vec %0d response strobe", i));
            check(e == VECS[i].err, int'(VECS[i].req), 256'(e), 256'(VECS[i].err),
                  $sformatf("vec %0d error", i));
            check(rd == VECS[i].rdata, int'(VECS[i].req), 256'(rd), 256'(VECS[i].rdata),
                  $sformatf("vec %0d data", i));
        end

        // R11: idle cycle gives no response
        @(negedge clk);
        check(rsp_valid == 1'b0, 11, 256'(rsp_valid), 256'(0), "idle has no response");

        // R12: region outputs after the table
        check(cfg_en == 8'h84, 12, 256'(cfg_en), 256'(8'h84), "enable vector");
        check(cfg_base[7*27 +: 27] == 27'h400_0000, 12, 256'(cfg_base[7*27 +: 27]),
              256'(27'h400_0000), "region 7 base");
        check(cfg_base[3*27 +: 27] == 27'h100_0007, 3, 256'(cfg_base[3*27 +: 27]),
              256'(27'h100_0007), "region 3 base");
        check(cfg_srd[5*8 +: 8] == 8'h55 && cfg_size[5*5 +: 5] == 5'd3, 8,
              256'({cfg_srd[5*8 +: 8], cfg_size[5*5 +: 5]}), 256'({8'h55, 5'd3}), "region 5 srd/size");
        check(cfg_attr[7*16 +: 16] == 16'h0300 && cfg_attr[5*16 +: 16] == 16'h0001, 6,
              256'({cfg_attr[7*16 +: 16], cfg_attr[5*16 +: 16]}), 256'({16'h0300, 16'h0001}),
              "attribute fields");

        // R7: clear the enable of region 2 with a halfword write
        xfer(1'b1, 6'h08, 2'd1, 32'h0, v, e, rd);
        check(cfg_en == 8'h80, 7, 256'(cfg_en), 256'(8'h80), "halfword disable region 2");
        xfer(1'b1, 6'h08, 2'd0, 32'h0000_0001, v, e, rd);
        check(cfg_en == 8'h84, 12, 256'(cfg_en), 256'(8'h84), "byte enable region 2");

        // R10: error write to the alias attribute leaves region 2 alone
        xfer(1'b1, 6'h12, 2'd2, 32'h0, v, e, rd);
        check(e == 1'b1 && cfg_en == 8'h84, 10, 256'({e, cfg_en}), 256'({1'b1, 8'h84}),
              "misaligned alias write ignored");

        // R1: reset again in mid-run
        do_reset();
        check(cfg_en == '0 && cfg_base == '0 && cfg_srd == '0, 1, 256'(cfg_en), 256'(0),
              "outputs cleared by reset");
        xfer(1'b0, 6'h04, 2'd2, 32'h0, v, e, rd);
        check(rd == 32'h0, 1, 256'(rd), 256'(0), "base readback after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog expired: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule